// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two W-bit operands (W = 32 by default) over several clock cycles. It uses one adder and a single 2W-bit product register. A start pulse loads the multiplier operand into the low half of the product register and clears the upper half. In each iteration the unit looks at the least significant bit of the product register. When that bit is one, it adds the multiplicand into the upper half. It then shifts the whole register right by one place. The carry out of the add is kept and enters at the top, so the growing product fills the bits that the spent multiplier bits leave free.

In signed mode the operands are first reduced to magnitudes and the sign of the result is noted. The magnitudes are multiplied as unsigned numbers, and the 2W-bit result is negated at the end when the sign is negative. The finished product appears as a high word and a low word. A fit flag says whether the product could be held in the low word alone. The product itself is never changed by this check.

Top module: `shiftadd_mul`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0, `hi` and `lo` are 0 and `fits` is 1.
- R2: A `start` sampled high while `busy` is 0 is accepted. `busy` is 1 for the next W+1 cycles. `done` is 1 for exactly the one cycle after the last busy cycle. `busy` and `done` are never 1 together.
- R3: With `is_signed` = 0, `{hi,lo}` equals the unsigned 2W-bit product of `opa` and `opb`. This includes operands with all ones, where the adder carry must be kept (for example, 0010 times 1011 gives 00010110).
- R4: With `is_signed` = 1, `{hi,lo}` equals the two's complement 2W-bit product of the operands. This includes the most negative value on one or both sides.
- R5: With `is_signed` = 0, `fits` is 1 exactly when `hi` is zero.
- R6: With `is_signed` = 1, `fits` is 1 exactly when every bit of `hi` equals bit W-1 of `lo`.
- R7: A `start` that arrives while `busy` is 1 has no effect. The running product and its timing continue unchanged.
- R8: `hi`, `lo` and `fits` change only in the cycle where `done` is 1, and they hold their values until the next completion.
- R9: `opa`, `opb` and `is_signed` are sampled only when a start is accepted. Changing them during the operation does not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiply; honoured only when idle |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| opa | input | W | Multiplicand |
| opb | input | W | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| hi | output | W | Upper word of the product |
| lo | output | W | Lower word of the product |
| fits | output | 1 | Product is representable in `lo` alone |

## Verification
The bench aims at the operand pairs where a shortcut breaks. All-ones unsigned operands lose the top product bits if the adder carry is dropped. The most negative signed value has no positive counterpart in W signed bits, so a magnitude stage that keeps a sign bit would give a wrong product. A negative times zero shows whether the negation step wrongly produces a nonzero result. Starts issued mid-run, with altered operands and mode, would corrupt the result or restart the count in a design that samples its inputs outside the accepted start. Back-to-back operations would show an off-by-one in the `done` and `busy` timing on every cycle.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mul_state_e;

  localparam int unsigned DEFAULT_WIDTH = 32;

endpackage

// File: rtl/mul_prep.sv
// Operand conditioning: turns signed operands into magnitudes and works out
// the sign of the product. Purely combinational; the top registers its outputs.
module mul_prep #(
  parameter int unsigned W = 32
) (
  input  logic         is_signed,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         negate
);

  localparam int unsigned NOPS = 2;

  logic [NOPS-1:0][W-1:0] raw;
  logic [NOPS-1:0][W-1:0] mag;
  logic [NOPS-1:0]        is_neg;

  assign raw[0] = opa;
  assign raw[1] = opb;

  for (genvar i = 0; i < NOPS; i++) begin : g_mag
    // In signed mode the sign bit selects the two's complement negation.
    // The most negative value maps to 2^(W-1), which still fits in W unsigned bits.
    assign is_neg[i] = is_signed & raw[i][W-1];
    assign mag[i]    = is_neg[i] ? (~raw[i] + {{(W-1){1'b0}}, 1'b1}) : raw[i];
  end

  assign mag_a  = mag[0];
  assign mag_b  = mag[1];
  assign negate = is_neg[0] ^ is_neg[1];

endmodule

// File: rtl/mul_core.sv
// Product register with one adder: test LSB, add multiplicand into the upper
// half, keep the carry, shift everything right by one.
module mul_core #(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic [2*W-1:0] prod
);

  localparam int unsigned PW = 2 * W;

  logic [W-1:0]  mcand_q;
  logic [PW-1:0] prod_q;
  logic [W:0]    addend;
  logic [W:0]    upper_sum;

  assign addend    = prod_q[0] ? {1'b0, mcand_q} : '0;
  assign upper_sum = {1'b0, prod_q[PW-1:W]} + addend;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load) begin
      mcand_q <= mcand_in;
      prod_q  <= {{W{1'b0}}, mplier_in};
    end else if (step) begin
      // W+1 sum bits plus the W-1 surviving low bits give PW bits.
      prod_q  <= {upper_sum, prod_q[W-1:1]};
    end
  end

  assign prod = prod_q;

  // R7 / R9: the multiplicand is not reloaded while iterating.
  p_mcand_held_r9: assert property (@(posedge clk) disable iff (rst)
    step |=> $stable(mcand_q));

  p_load_step_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(load && step));

endmodule

// File: rtl/mul_fix.sv
// Result stage: applies the sign, splits into words, evaluates the fit flag,
// and registers everything together with the done pulse.
module mul_fix #(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           capture,
  input  logic           negate,
  input  logic           sgn_mode,
  input  logic [2*W-1:0] prod_in,
  output logic [W-1:0]   hi,
  output logic [W-1:0]   lo,
  output logic           fits,
  output logic           done
);

  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] signed_res;
  logic [W-1:0]  res_hi;
  logic [W-1:0]  res_lo;
  logic          res_fit;

  assign signed_res = negate ? (~prod_in + {{(PW-1){1'b0}}, 1'b1}) : prod_in;
  assign res_hi     = signed_res[PW-1:W];
  assign res_lo     = signed_res[W-1:0];

  always_comb begin
    if (sgn_mode) res_fit = (res_hi == {W{res_lo[W-1]}});
    else          res_fit = (res_hi == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi   <= '0;
      lo   <= '0;
      fits <= 1'b1;
      done <= 1'b0;
    end else begin
      done <= capture;
      if (capture) begin
        hi   <= res_hi;
        lo   <= res_lo;
        fits <= res_fit;
      end
    end
  end

  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(hi) && $stable(lo) && $stable(fits)));

  p_fits_small_r5: assert property (@(posedge clk) disable iff (rst)
    (done && hi == '0 && !lo[W-1]) |-> fits);

  p_nofit_wide_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !fits) |-> ((hi != '0) || lo[W-1]));

endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul
  import mul_pkg::*;
#(
  parameter int unsigned W = mul_pkg::DEFAULT_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  output logic         fits
);

  localparam int unsigned CW = $clog2(W + 1);
  localparam int unsigned LW = $clog2(W + 3);
  localparam logic [CW-1:0] LAST_ITER = CW'(W - 1);

  mul_state_e    state_q;
  logic [CW-1:0] iter_q;
  logic          busy_q;
  logic          neg_q;
  logic          sgn_q;
  logic          load;
  logic          step;
  logic          capture;
  logic [W-1:0]  mag_a;
  logic [W-1:0]  mag_b;
  logic          negate;
  logic [2*W-1:0] prod;

  assign load    = (state_q == ST_IDLE) && start;
  assign step    = (state_q == ST_RUN);
  assign capture = (state_q == ST_FIN);

  mul_prep #(.W(W)) u_prep (
    .is_signed (is_signed),
    .opa       (opa),
    .opb       (opb),
    .mag_a     (mag_a),
    .mag_b     (mag_b),
    .negate    (negate)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
      busy_q  <= 1'b0;
      neg_q   <= 1'b0;
      sgn_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            iter_q  <= '0;
            busy_q  <= 1'b1;
            neg_q   <= negate;
            sgn_q   <= is_signed;
          end
        end
        ST_RUN: begin
          if (iter_q == LAST_ITER) begin
            state_q <= ST_FIN;
            iter_q  <= '0;
          end else begin
            iter_q  <= iter_q + 1'b1;
          end
        end
        ST_FIN: begin
          state_q <= ST_IDLE;
          busy_q  <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  mul_core #(.W(W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (step),
    .mcand_in  (mag_a),
    .mplier_in (mag_b),
    .prod      (prod)
  );

  mul_fix #(.W(W)) u_fix (
    .clk      (clk),
    .rst      (rst),
    .capture  (capture),
    .negate   (neg_q),
    .sgn_mode (sgn_q),
    .prod_in  (prod),
    .hi       (hi),
    .lo       (lo),
    .fits     (fits),
    .done     (done)
  );

  assign busy = busy_q;

  // Busy-length counter used only by the R2 check below.
  logic [LW-1:0] run_len_q;
  always_ff @(posedge clk) begin
    if (rst)                           run_len_q <= '0;
    else if (load)                     run_len_q <= LW'(1);
    else if (busy_q && !capture)       run_len_q <= run_len_q + 1'b1;
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_len_q == LW'(W + 1)));

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (step && start) |=> busy);

endmodule

// File: tb/shiftadd_mul_bench.sv
module shiftadd_mul_bench;

  localparam int unsigned W  = 32;
  localparam int unsigned PW = 2 * W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         is_signed = 1'b0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] hi;
  logic [W-1:0] lo;
  logic         fits;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  shiftadd_mul #(.W(W)) u_shiftadd_mul (
    .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
    .opa(opa), .opb(opb), .busy(busy), .done(done),
    .hi(hi), .lo(lo), .fits(fits)
  );

  function automatic logic [PW-1:0] ref_prod(input logic [W-1:0] a,
                                             input logic [W-1:0] b,
                                             input logic s);
    logic signed [PW-1:0] sa, sb;
    logic [PW-1:0] ua, ub;
    if (s) begin
      sa = $signed(a);
      sb = $signed(b);
      return sa * sb;
    end
    ua = {{W{1'b0}}, a};
    ub = {{W{1'b0}}, b};
    return ua * ub;
  endfunction

  function automatic logic ref_fit(input logic [PW-1:0] p, input logic s);
    if (s) return p[PW-1:W] == {W{p[W-1]}};
    return p[PW-1:W] == '0;
  endfunction

  task automatic check(input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Behavioural cycle model.
  logic          m_busy = 1'b0;
  logic          m_done = 1'b0;
  int            m_left = 0;
  logic          m_sgn  = 1'b0;
  logic [PW-1:0] m_pend = '0;
  logic [PW-1:0] m_out  = '0;
  logic          m_fit  = 1'b1;
  logic          m_osgn = 1'b0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_busy = 1'b0; m_done = 1'b0; m_left = 0;
      m_out = '0; m_fit = 1'b1;
    end else begin
      m_done = 1'b0;
      if (!m_busy && start) begin
        m_busy = 1'b1;
        m_left = W + 1;
        m_sgn  = is_signed;
        m_pend = ref_prod(opa, opb, is_signed);
      end else if (m_busy) begin
        if (m_left == 1) begin
          m_busy = 1'b0;
          m_done = 1'b1;
          m_out  = m_pend;
          m_fit  = ref_fit(m_pend, m_sgn);
          m_osgn = m_sgn;
        end
        m_left = m_left - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R2 busy", PW'(busy), PW'(m_busy));
      check("R2 done", PW'(done), PW'(m_done));
      if (m_done) begin
        check(m_osgn ? "R4 product" : "R3 product", {hi, lo}, m_out);
        check(m_osgn ? "R6 fits" : "R5 fits", PW'(fits), PW'(m_fit));
      end else begin
        check("R8 hold", {hi, lo}, m_out);
        check("R8 fits hold", PW'(fits), PW'(m_fit));
      end
    end
  end

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic s, input bit noisy);
    @(negedge clk);
    start = 1'b1; opa = a; opb = b; is_signed = s;
    @(negedge clk);
    start = 1'b0;
    if (noisy) begin
      repeat (4) @(negedge clk);
      start = 1'b1; opa = ~a; opb = b + 1'b1; is_signed = ~s;
      @(negedge clk);
      start = 1'b0; opa = a ^ 32'h5a5a_5a5a; is_signed = ~s;
    end
    while (!done) @(negedge clk);
    if (noisy) begin
      check("R7 start while busy ignored", {hi, lo}, ref_prod(a, b, s));
      check("R9 inputs sampled at start", PW'(fits), PW'(ref_fit(ref_prod(a, b, s), s)));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset busy/done", {busy, done}, '0);
    check("R1 reset hi/lo", {hi, lo}, '0);
    check("R1 reset fits", PW'(fits), PW'(1));
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {busy, done, fits}, PW'(1));

    run_op(32'd2, 32'd11, 1'b0, 1'b0);                 // R3 small example
    check("R3 2x11", {hi, lo}, PW'(22));
    run_op(32'hffff_ffff, 32'hffff_ffff, 1'b0, 1'b0);  // R3 carry kept, R5 no fit
    run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0);  // R4 most negative squared
    run_op(32'h8000_0000, 32'd1, 1'b1, 1'b0);          // R6 fits
    run_op(32'h8000_0000, 32'hffff_ffff, 1'b1, 1'b0);  // R4, R6 overflow
    run_op(32'hffff_fffd, 32'd0, 1'b1, 1'b0);          // R4 negative times zero
    run_op(32'hffff_ffff, 32'hffff_ffff, 1'b1, 1'b0);  // R4 -1 x -1
    run_op(32'hffff_fffd, 32'd5, 1'b1, 1'b0);          // R4 -3 x 5
    run_op(32'h1234_5678, 32'h9abc_def0, 1'b0, 1'b1);  // R7, R9 unsigned
    run_op(32'h8765_4321, 32'h0000_0003, 1'b1, 1'b1);  // R7, R9 signed
    for (int i = 0; i < 60; i++) begin
      run_op($urandom, $urandom, i[0], i % 7 == 3);
      if (i % 5 == 0) repeat (i % 3) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule